// File: doc/BRIEF.md
# Next-PC Branch and Jump Unit

This block owns the 32-bit program counter of a simple in-order fetch stage and works out, every enabled cycle, where fetch goes next. It looks only at the fields of the fetched instruction word that steer control flow: the opcode in the top six bits, the low 16-bit signed offset and the low 26-bit jump field. Whether the two compared source registers are equal comes in from outside as a single bit. The register file, the ALU and the write of the link register all belong to other blocks.

Four flows are handled: straight-line stepping to the next word, the two conditional branches (taken on equal or on not-equal), a plain jump, and a jump that also hands back a return address. Branch offsets count instructions, not bytes, and are applied to the address of the following instruction. Jump fields are word addresses placed under the top four bits of that same following address. For the linking jump, the block raises a flag and presents PC+4 so that the register file can store it.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc` becomes 0x00000000 after that edge, whatever `en` and the other inputs are.
- R2: When `en` is low at a rising edge (and `rst` is low), `pc` keeps its value, even if the instruction is a taken branch or a jump.
- R3: An opcode of 0 (register format, `instr[31:26]` = 0) moves `pc` to `pc` + 4 on an enabled edge.
- R4: Opcode 4 (equal-branch) with `regs_equal` = 1 moves `pc` to (`pc` + 4) + 4 × sign-extended `instr[15:0]`; with `regs_equal` = 0 it moves to `pc` + 4.
- R5: Opcode 5 (not-equal branch) with `regs_equal` = 0 moves `pc` to (`pc` + 4) + 4 × sign-extended `instr[15:0]`; with `regs_equal` = 1 it moves to `pc` + 4.
- R6: A branch offset with bit 15 set counts backwards: offset 0xFFFF returns to the branch itself, and 0x8000 goes 32768 instructions back from `pc` + 4.
- R7: Opcode 2 (jump) moves `pc` to {(`pc` + 4)[31:28], `instr[25:0]`, 2'b00}, independent of `regs_equal`; the top nibble comes from `pc` + 4 even when that carries out of the current nibble.
- R8: Opcode 3 (linking jump) moves `pc` to the same target as R7, and while it is presented `link_valid` is 1 and `link_addr` equals `pc` + 4.
- R9: For any opcode other than 3, `link_valid` is 0.
- R10: Any opcode other than 2, 3, 4 and 5 moves `pc` to `pc` + 4 on an enabled edge, regardless of `regs_equal` and of the remaining instruction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| en | input | 1 | Advance enable; the counter updates only when high |
| instr | input | 32 | Instruction word fetched at the current `pc` |
| regs_equal | input | 1 | High when the two compared source registers hold equal values |
| pc | output | 32 | Current program counter (byte address) |
| link_addr | output | 32 | Return address `pc` + 4 |
| link_valid | output | 1 | High while the presented instruction is the linking jump |

## Verification
The new program counter is due one rising edge after the instruction and compare bit are presented, since the only register on the path is the counter itself; `link_valid` and `link_addr` are combinational and are due in the same cycle. The driver therefore presents each instruction just after a falling edge, checks the link outputs a moment later in that same half-cycle, and queues the predicted counter value; the monitor pops that value one time step after the next rising edge and compares it with `pc`. Predictions are kept in the bench as a running model of the counter, so a held or reset counter is predicted the same way as a moving one.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = 26;
  localparam int unsigned ALIGN_W = 2;
  localparam int unsigned OPC_LSB = WORD_W - OPC_W;
  localparam int unsigned SEG_W   = WORD_W - TGT_W - ALIGN_W;
  localparam int unsigned EXT_W   = WORD_W - IMM_W - ALIGN_W;
  localparam int unsigned STEP    = 1 << ALIGN_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OPC_W-1:0]  opc_t;
  typedef logic [IMM_W-1:0]  imm_t;
  typedef logic [TGT_W-1:0]  tgt_t;

  typedef enum logic [OPC_W-1:0] {
    OPC_REG  = 6'd0,
    OPC_JMP  = 6'd2,
    OPC_JAL  = 6'd3,
    OPC_BEQ  = 6'd4,
    OPC_BNE  = 6'd5
  } opc_e;

  typedef enum logic [2:0] {
    FLOW_SEQ = 3'd0,
    FLOW_BEQ = 3'd1,
    FLOW_BNE = 3'd2,
    FLOW_JMP = 3'd3,
    FLOW_JAL = 3'd4
  } flow_e;

  // Address of the following instruction.
  function automatic word_t step_addr(input word_t cur);
    return cur + word_t'(STEP);
  endfunction

  // Relative branch: offset counts instructions from the following one.
  function automatic word_t branch_addr(input word_t base, input imm_t ofs);
    return base + {{EXT_W{ofs[IMM_W-1]}}, ofs, {ALIGN_W{1'b0}}};
  endfunction

  // Region jump: word field placed under the top segment of base.
  function automatic word_t jump_addr(input word_t base, input tgt_t fld);
    return {base[WORD_W-1 -: SEG_W], fld, {ALIGN_W{1'b0}}};
  endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output flow_e             flow,
  output logic [IMM_W-1:0]  imm,
  output logic [TGT_W-1:0]  tgt
);

  opc_t opc;

  assign opc = instr[OPC_LSB +: OPC_W];
  assign imm = instr[IMM_W-1:0];
  assign tgt = instr[TGT_W-1:0];

  always_comb begin
    case (opc)
      OPC_BEQ: flow = FLOW_BEQ;
      OPC_BNE: flow = FLOW_BNE;
      OPC_JMP: flow = FLOW_JMP;
      OPC_JAL: flow = FLOW_JAL;
      default: flow = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  flow_e flow,
  input  logic  regs_equal,
  output logic  take_branch,
  output logic  take_jump,
  output logic  is_link
);

  always_comb begin
    take_branch = 1'b0;
    take_jump   = 1'b0;
    is_link     = 1'b0;
    unique case (flow)
      FLOW_BEQ: take_branch = regs_equal;
      FLOW_BNE: take_branch = ~regs_equal;
      FLOW_JMP: take_jump   = 1'b1;
      FLOW_JAL: begin
        take_jump = 1'b1;
        is_link   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/npc_addr.sv
module npc_addr
  import npc_pkg::*;
(
  input  logic [WORD_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic [TGT_W-1:0]  tgt,
  output logic [WORD_W-1:0] seq_addr,
  output logic [WORD_W-1:0] br_addr,
  output logic [WORD_W-1:0] jmp_addr
);

  assign seq_addr = step_addr(pc);
  assign br_addr  = branch_addr(seq_addr, imm);
  assign jmp_addr = jump_addr(seq_addr, tgt);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] instr,
  input  logic        regs_equal,
  output logic [31:0] pc,
  output logic [31:0] link_addr,
  output logic        link_valid
);

  flow_e            flow;
  logic [IMM_W-1:0] imm;
  logic [TGT_W-1:0] tgt;
  logic             take_branch;
  logic             take_jump;
  logic             is_link;
  word_t            seq_addr;
  word_t            br_addr;
  word_t            jmp_addr;
  word_t            next_pc;
  word_t            pc_q;

  npc_decode u_decode (
    .instr (instr),
    .flow  (flow),
    .imm   (imm),
    .tgt   (tgt)
  );

  npc_cond u_cond (
    .flow        (flow),
    .regs_equal  (regs_equal),
    .take_branch (take_branch),
    .take_jump   (take_jump),
    .is_link     (is_link)
  );

  npc_addr u_addr (
    .pc       (pc_q),
    .imm      (imm),
    .tgt      (tgt),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .jmp_addr (jmp_addr)
  );

  always_comb begin
    if (take_jump)        next_pc = jmp_addr;
    else if (take_branch) next_pc = br_addr;
    else                  next_pc = seq_addr;
  end

  always_ff @(posedge clk) begin
    if (rst)     pc_q <= RESET_PC;
    else if (en) pc_q <= next_pc;
  end

  assign pc         = pc_q;
  assign link_addr  = seq_addr;
  assign link_valid = is_link;

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc == RESET_PC);

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !take_branch && !take_jump) |=> pc == $past(pc) + 32'd4);

  // R4
  branch_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (en && take_branch) |=> pc == $past(br_addr));

  // R7
  jump_region_chk: assert property (@(posedge clk) disable iff (rst)
    (en && take_jump) |=> (pc[1:0] == 2'b00) && (pc[31:28] == $past(seq_addr[31:28])));

  // R7
  single_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    !(take_branch && take_jump));

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (link_addr == pc + 32'd4) && take_jump);

  // R9
  link_only_jal_chk: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != 6'd3) |-> !link_valid);

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [31:0] instr;
  logic        regs_equal;
  logic [31:0] pc;
  logic [31:0] link_addr;
  logic        link_valid;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  logic [31:0] model_pc;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  npc_unit uut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .instr      (instr),
    .regs_equal (regs_equal),
    .pc         (pc),
    .link_addr  (link_addr),
    .link_valid (link_valid)
  );

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [25:0] rest);
    return {op, rest};
  endfunction

  // Independent prediction of the next counter value.
  function automatic logic [31:0] predict(input logic [31:0] cur, input logic [31:0] w,
                                          input logic eq, input logic e, input logic r);
    logic [31:0] nxt;
    int          ofs;
    if (r) return 32'h0;
    if (!e) return cur;
    nxt = cur + 32'd4;
    ofs = int'($signed(w[15:0])) * 4;
    case (w[31:26])
      6'd4: if (eq)  nxt = cur + 32'd4 + 32'(ofs);
      6'd5: if (!eq) nxt = cur + 32'd4 + 32'(ofs);
      6'd2, 6'd3: nxt = ((cur + 32'd4) & 32'hF000_0000) | (32'(w[25:0]) << 2);
      default: ;
    endcase
    return nxt;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: presents one instruction, checks same-cycle link outputs, queues next pc.
  task automatic drive(input string req, input logic [31:0] w, input logic eq,
                       input logic e, input logic r);
    @(negedge clk);
    rst = r; en = e; instr = w; regs_equal = eq;
    #0.5;
    if (!r) begin
      if (w[31:26] == 6'd3) begin
        check({req, " R8 link_valid"}, 32'(link_valid), 32'd1);
        check({req, " R8 link_addr"}, link_addr, model_pc + 32'd4);
      end else begin
        check({req, " R9 link_valid"}, 32'(link_valid), 32'd0);
      end
    end
    model_pc = predict(model_pc, w, eq, e, r);
    exp_q.push_back(model_pc);
    tag_q.push_back(req);
  endtask

  // Monitor: compares each queued prediction after the edge that produces it.
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string       t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, pc, e);
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; instr = '0; regs_equal = 1'b0;
    model_pc = 32'h0;
    drive("R1 reset", 32'h0, 1'b0, 1'b1, 1'b1);
    drive("R1 reset", 32'h0800_0010, 1'b1, 1'b1, 1'b1);
    drive("R3 reg-format add", 32'h012A_4020, 1'b0, 1'b1, 1'b0);
    drive("R3 reg-format eq", mk_i(6'd0, 26'h3FF_FFFF), 1'b1, 1'b1, 1'b0);
    drive("R5 bne not taken", mk_i(6'd5, 26'h000_0040), 1'b1, 1'b1, 1'b0);
    drive("R4 beq loop exit +3", 32'h1120_0003, 1'b1, 1'b1, 1'b0);
    drive("R4 beq not taken", mk_i(6'd4, 26'h000_0100), 1'b0, 1'b1, 1'b0);
    drive("R5 bne taken fwd", mk_i(6'd5, 26'h000_0010), 1'b0, 1'b1, 1'b0);
    drive("R6 beq backward -5", mk_i(6'd4, 26'h000_FFFB), 1'b1, 1'b1, 1'b0);
    drive("R6 bne to self", mk_i(6'd5, 26'h000_FFFF), 1'b0, 1'b1, 1'b0);
    drive("R7 jump 20000", mk_i(6'd2, 26'd20000), 1'b0, 1'b1, 1'b0);
    drive("R6 beq most negative", mk_i(6'd4, 26'h000_8000), 1'b1, 1'b1, 1'b0);
    drive("R2 hold on jump", mk_i(6'd2, 26'h123_4567), 1'b0, 1'b0, 1'b0);
    drive("R2 hold on branch", mk_i(6'd4, 26'h000_0020), 1'b1, 1'b0, 1'b0);
    drive("R7 jump top of region", mk_i(6'd2, 26'h3FF_FFFF), 1'b1, 1'b1, 1'b0);
    drive("R8 jal across region", mk_i(6'd3, 26'h000_0040), 1'b0, 1'b1, 1'b0);
    drive("R8 jal again", mk_i(6'd3, 26'h155_5555), 1'b1, 1'b1, 1'b0);
    drive("R10 load op", mk_i(6'h23, 26'h3FF_8000), 1'b1, 1'b1, 1'b0);
    drive("R10 store op", mk_i(6'h2B, 26'h000_FFFF), 1'b0, 1'b1, 1'b0);
    drive("R10 op 1", mk_i(6'd1, 26'h3FF_FFF0), 1'b1, 1'b1, 1'b0);
    drive("R10 op 6", mk_i(6'd6, 26'h000_8000), 1'b0, 1'b1, 1'b0);
    drive("R10 op 7", mk_i(6'd7, 26'h000_7FFF), 1'b1, 1'b1, 1'b0);
    drive("R10 op 63", mk_i(6'h3F, 26'h3FF_FFFF), 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++)
      drive("R3 run", mk_i(6'd0, 26'(k * 77)), k[0], 1'b1, 1'b0);
    drive("R1 reset mid-run", mk_i(6'd2, 26'h0AB_CDEF), 1'b1, 1'b0, 1'b1);
    drive("R3 after reset", 32'h0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule